// File: doc/BRIEF.md
# Reset Cause Hub

This block gathers every reset request of the chip into a single synchronous chip reset. It also keeps a sticky record of which sources have fired since the last power-up. There are six sources: power-on detect, brownout detect, an external reset pin, a watchdog expiry, a software reset request and a break condition seen by a serial receiver. Every source except power-on passes through its own enable. Brownout is the exception in polarity: its control is a disable.

Power-on detect acts as the block's own asynchronous reset. It loads the cause register with the power-on and brownout flags both set. Every other reset sets only its own flag and leaves earlier, uncleared flags alone, so software can read back the full history after several resets. Software clears a flag by writing 0 to its bit through a plain read/write port.

The asynchronous sources are synchronized before use. The chip reset output is held for a fixed number of clocks after the last active source goes away.

Top module: `rst_cause_hub`

## Requirements
- R1: `reg_rdata` bit 0 is the external pin flag, bit 1 the software flag, bit 2 the watchdog flag, bit 3 the break flag, bit 4 the power-on flag and bit 5 the brownout flag. Bits 7:6 always read 0 and ignore writes.
- R2: While `por_req` is high, `reg_rdata` reads 8'h30 and `chip_rst` is 1. All other flags are cleared.
- R3: A non-power-on reset sets its own flag and leaves every other flag unchanged.
- R4: A write with `reg_we` high clears each flag whose `reg_wdata` bit is 0. A written 1 leaves the flag as it was.
- R5: If a write clears a flag in the same cycle that its source sets it, the flag ends up set.
- R6: If the external pin is held, and enabled, when `por_req` falls, the external flag is set once the pin has passed the synchronizer (result 8'h31).
- R7: A source whose gate is off sets no flag and does not assert `chip_rst`. The gates are `ext_rst_en`, `wdt_rst_en` and `brk_rst_en` (each active when 1) and `bod_rst_dis` (gate off when 1).
- R8: `chip_rst` goes high on the edge that registers an active gated source. It stays high for exactly HOLD_CYCLES (4) clock cycles after the last cycle in which a source was active.
- R9: A one-cycle `sw_rst_req` pulse sets bit 1 and asserts `chip_rst` on the next clock edge. No synchronizer is involved.
- R10: A change on an asynchronous source (pin, watchdog, break, brownout) reaches the cause register on the third rising edge after it is applied (SYNC_STAGES = 2).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_req | input | 1 | Power-on detect, active high, asynchronous; resets the block |
| bod_req | input | 1 | Brownout detect, asynchronous |
| bod_rst_dis | input | 1 | 1 stops brownout from causing a reset |
| ext_rst | input | 1 | External reset pin level, active high, asynchronous |
| ext_rst_en | input | 1 | 1 lets the pin cause a reset |
| wdt_expire | input | 1 | Watchdog expiry, asynchronous |
| wdt_rst_en | input | 1 | 1 lets the watchdog cause a reset |
| brk_det | input | 1 | Serial receiver break condition, asynchronous |
| brk_rst_en | input | 1 | 1 lets a break cause a reset |
| sw_rst_req | input | 1 | Synchronous software reset request |
| reg_we | input | 1 | Write strobe for the cause register |
| reg_wdata | input | 8 | Write data; a 0 bit clears the matching flag |
| reg_rdata | output | 8 | Cause register contents |
| chip_rst | output | 1 | Synchronous chip reset, active high |

## Verification
Each asynchronous source is applied in turn with its gate open and then with it closed. This separates correct gating from a stuck or swapped enable, and the growing register value shows that earlier flags survive. Power-on is applied twice, once with the pin idle and once with it held, to tell the 8'h30 load apart from the post-power-on pin capture. Write patterns of all zeros, all ones and a single zero separate clearing from write-one immunity. A clear issued while the watchdog is still active exposes the set-versus-clear priority. A one-cycle software pulse measures the exact hold length of the reset output.

// File: rtl/rst_cause_hub.sv
module rst_cause_hub #(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 4
) (
  input  logic       clk,
  input  logic       por_req,
  input  logic       bod_req,
  input  logic       bod_rst_dis,
  input  logic       ext_rst,
  input  logic       ext_rst_en,
  input  logic       wdt_expire,
  input  logic       wdt_rst_en,
  input  logic       brk_det,
  input  logic       brk_rst_en,
  input  logic       sw_rst_req,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       chip_rst
);
  localparam int NASYNC = 4;
  localparam int NFLAG  = 6;
  localparam int CW     = $clog2(HOLD_CYCLES + 1);
  localparam logic [NFLAG-1:0] POR_VALUE = 6'b110000;

  logic [SYNC_STAGES-1:0][NASYNC-1:0] sync_q;
  logic [NASYNC-1:0] async_in, async_s;
  logic [NFLAG-1:0]  flags, set_vec, keep_mask;
  logic [CW-1:0]     hold_cnt;

  assign async_in = {bod_req, brk_det, wdt_expire, ext_rst};

  always_ff @(posedge clk or posedge por_req) begin
    if (por_req) begin
      sync_q <= '0;
    end else begin
      sync_q[0] <= async_in;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign async_s = sync_q[SYNC_STAGES-1];

  assign set_vec[0] = async_s[0] & ext_rst_en;
  assign set_vec[1] = sw_rst_req;
  assign set_vec[2] = async_s[1] & wdt_rst_en;
  assign set_vec[3] = async_s[2] & brk_rst_en;
  assign set_vec[4] = 1'b0;
  assign set_vec[5] = async_s[3] & ~bod_rst_dis;

  assign keep_mask = reg_we ? reg_wdata[NFLAG-1:0] : '1;

  always_ff @(posedge clk or posedge por_req) begin
    if (por_req) flags <= POR_VALUE;
    else         flags <= (flags & keep_mask) | set_vec;
  end

  always_ff @(posedge clk or posedge por_req) begin
    if (por_req)            hold_cnt <= CW'(HOLD_CYCLES);
    else if (|set_vec)      hold_cnt <= CW'(HOLD_CYCLES);
    else if (hold_cnt != 0) hold_cnt <= hold_cnt - 1'b1;
  end

  assign chip_rst  = (hold_cnt != '0);
  assign reg_rdata = {2'b00, flags};
endmodule

module rst_cause_hub_chk (
  input logic       clk,
  input logic       por_req,
  input logic       sw_rst_req,
  input logic       brk_rst_en,
  input logic       reg_we,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       chip_rst
);
  always @(negedge clk) begin
    if (por_req) begin
      a_r2_por_value: assert (reg_rdata == 8'h30 && chip_rst)
        else $error("power-on value wrong");
    end
  end

  a_r3_sticky: assert property (@(posedge clk) disable iff (por_req)
    !reg_we |=> ((reg_rdata & $past(reg_rdata)) == $past(reg_rdata)));

  a_r4_one_keeps: assert property (@(posedge clk) disable iff (por_req)
    reg_we |=> ((reg_rdata & $past(reg_rdata & reg_wdata)) == $past(reg_rdata & reg_wdata)));

  a_r9_sw_reset: assert property (@(posedge clk) disable iff (por_req)
    sw_rst_req |=> (chip_rst && reg_rdata[1]));

  a_r7_brk_gate: assert property (@(posedge clk) disable iff (por_req)
    (!$past(brk_rst_en) && !$past(reg_rdata[3])) |-> !reg_rdata[3]);

  a_r8_no_early_release: assert property (@(posedge clk) disable iff (por_req)
    $fell(chip_rst) |-> !$past(sw_rst_req));
endmodule

bind rst_cause_hub rst_cause_hub_chk u_chk (
  .clk(clk), .por_req(por_req), .sw_rst_req(sw_rst_req), .brk_rst_en(brk_rst_en),
  .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .chip_rst(chip_rst)
);

// File: tb/rst_cause_hub_tb.sv
module rst_cause_hub_tb;
  localparam int PERIOD = 10;
  localparam int SYNC   = 2;
  localparam int HOLD   = 4;

  logic clk = 1'b0;
  logic por_req = 1'b1;
  logic bod_req = 1'b0, bod_rst_dis = 1'b0;
  logic ext_rst = 1'b0, ext_rst_en = 1'b1;
  logic wdt_expire = 1'b0, wdt_rst_en = 1'b1;
  logic brk_det = 1'b0, brk_rst_en = 1'b1;
  logic sw_rst_req = 1'b0;
  logic reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic chip_rst;

  int nvec = 0, nerr = 0;
  bit started = 0, done = 0;

  always #(PERIOD/2) clk = ~clk;

  rst_cause_hub #(.SYNC_STAGES(SYNC), .HOLD_CYCLES(HOLD)) u_dut (
    .clk(clk), .por_req(por_req), .bod_req(bod_req), .bod_rst_dis(bod_rst_dis),
    .ext_rst(ext_rst), .ext_rst_en(ext_rst_en), .wdt_expire(wdt_expire),
    .wdt_rst_en(wdt_rst_en), .brk_det(brk_det), .brk_rst_en(brk_rst_en),
    .sw_rst_req(sw_rst_req), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .chip_rst(chip_rst)
  );

  // behavioural reference model
  bit [5:0] m_flags;
  int       m_cnt;
  bit [3:0] m_pipe[$];

  always @(posedge clk) begin
    if (por_req) begin
      m_flags = 6'h30;
      m_cnt   = HOLD;
      m_pipe  = {};
      for (int i = 0; i < SYNC; i++) m_pipe.push_back(4'h0);
      started = 1;
    end else begin
      bit [3:0] s;
      bit [5:0] setv;
      s = m_pipe[SYNC-1];
      setv = 6'h0;
      if (s[0] && ext_rst_en)   setv[0] = 1;
      if (sw_rst_req)           setv[1] = 1;
      if (s[1] && wdt_rst_en)   setv[2] = 1;
      if (s[2] && brk_rst_en)   setv[3] = 1;
      if (s[3] && !bod_rst_dis) setv[5] = 1;
      if (reg_we) m_flags = m_flags & reg_wdata[5:0];
      m_flags = m_flags | setv;
      if (setv != 0)      m_cnt = HOLD;
      else if (m_cnt > 0) m_cnt = m_cnt - 1;
      m_pipe.push_front({bod_req, brk_det, wdt_expire, ext_rst});
      void'(m_pipe.pop_back());
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      nvec++;
      if (reg_rdata !== {2'b00, m_flags}) begin
        nerr++;
        $display("FAIL R3 per-cycle register: actual %h expected %h", reg_rdata, {2'b00, m_flags});
      end
      nvec++;
      if (chip_rst !== (m_cnt != 0)) begin
        nerr++;
        $display("FAIL R8 per-cycle chip_rst: actual %b expected %b", chip_rst, (m_cnt != 0));
      end
    end
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (HOLD + SYNC + 3) step();
  endtask

  task automatic gated_pulse(int which, string tag, logic [7:0] exp_reg);
    bit seen = 0;
    case (which)
      0: ext_rst = 1; 1: wdt_expire = 1; 2: brk_det = 1; default: bod_req = 1;
    endcase
    for (int k = 0; k < 6; k++) begin
      step();
      if (chip_rst) seen = 1;
    end
    ext_rst = 0; wdt_expire = 0; brk_det = 0; bod_req = 0;
    repeat (SYNC + 1) begin
      step();
      if (chip_rst) seen = 1;
    end
    check({tag, " chip_rst while gated"}, {7'b0, seen}, 8'h00);
    check({tag, " flags while gated"}, reg_rdata, exp_reg);
  endtask

  task automatic open_pulse(int which, string tag, logic [7:0] exp_reg);
    case (which)
      0: ext_rst = 1; 1: wdt_expire = 1; 2: brk_det = 1; default: bod_req = 1;
    endcase
    step();
    ext_rst = 0; wdt_expire = 0; brk_det = 0; bod_req = 0;
    repeat (SYNC) step();
    check({tag, " flag set"}, reg_rdata, exp_reg);
    check({tag, " chip_rst asserted"}, {7'b0, chip_rst}, 8'h01);
    settle();
  endtask

  initial begin
    int hi;
    repeat (3) step();
    check("R2 power-on value", reg_rdata, 8'h30);
    check("R2 chip_rst in power-on", {7'b0, chip_rst}, 8'h01);
    por_req = 0;
    repeat (HOLD + 2) step();
    check("R8 release after power-on", {7'b0, chip_rst}, 8'h00);

    reg_we = 1; reg_wdata = 8'h00; step(); reg_we = 0;
    check("R4 clear all", reg_rdata, 8'h00);
    reg_we = 1; reg_wdata = 8'hFF; step(); reg_we = 0;
    check("R1 R4 ones and reserved ignored", reg_rdata, 8'h00);

    sw_rst_req = 1; step(); sw_rst_req = 0;
    check("R9 software flag", reg_rdata, 8'h02);
    hi = chip_rst ? 1 : 0;
    for (int k = 0; k < 8; k++) begin
      step();
      if (chip_rst) hi++;
    end
    check("R8 hold length", 8'(hi), 8'(HOLD));

    wdt_expire = 1; step(); wdt_expire = 0; step();
    check("R10 not yet after two edges", reg_rdata, 8'h02);
    step();
    check("R10 R3 watchdog flag on third edge", reg_rdata, 8'h06);
    settle();

    wdt_rst_en = 0; gated_pulse(1, "R7 watchdog", 8'h06);
    brk_rst_en = 0; gated_pulse(2, "R7 break", 8'h06);
    bod_rst_dis = 1; gated_pulse(3, "R7 brownout", 8'h06);
    ext_rst_en = 0; gated_pulse(0, "R7 pin", 8'h06);

    brk_rst_en = 1; open_pulse(2, "R3 break", 8'h0E);
    bod_rst_dis = 0; open_pulse(3, "R3 brownout", 8'h2E);
    ext_rst_en = 1; open_pulse(0, "R3 pin", 8'h2F);

    reg_we = 1; reg_wdata = 8'hFB; step(); reg_we = 0;
    check("R4 single-bit clear", reg_rdata, 8'h2B);

    wdt_rst_en = 1; wdt_expire = 1;
    repeat (4) step();
    check("R5 watchdog active", reg_rdata, 8'h2F);
    reg_we = 1; reg_wdata = 8'h00; step(); reg_we = 0;
    check("R5 set beats clear", reg_rdata, 8'h04);
    wdt_expire = 0;
    settle();

    ext_rst = 1; por_req = 1;
    repeat (2) step();
    check("R2 power-on clears others", reg_rdata, 8'h30);
    por_req = 0;
    repeat (SYNC + 1) step();
    check("R6 pin held past power-on", reg_rdata, 8'h31);
    check("R6 chip_rst held", {7'b0, chip_rst}, 8'h01);
    ext_rst = 0;
    settle();
    check("R8 released at end", {7'b0, chip_rst}, 8'h00);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      done = 1;
      nerr++;
      $display("FAIL R8 watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule